// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

This block keeps a 16-bit count of activity on one external input. In event mode it adds one for each selected transition of the input. In gated mode it adds one for each strobe from an external prescaled-clock tick while the input sits at its active level. Two status flags record count wraparound and input activity, and a single interrupt request is raised from them under per-flag enables.

Software reaches the block through a small byte-addressed register port. There is one control byte, one flag byte and the count, which takes two byte addresses with the high byte at the lower address. Flags are cleared by writing ones to them. An optional fast-clear mode instead clears every flag on any access to the count. A word access moves all 16 count bits in one cycle, so it avoids the tearing that two separate byte accesses can show while the counter runs. The port is a plain register bus: read data is combinational and every access completes in the cycle it is presented, with no back-pressure.

Top module: `pulse_acc`

## Requirements
- R1: After reset the control byte (address 0), the flag byte (address 1) and the count (addresses 2 and 3) all read 0, and `irq` is 0.
- R2: In event mode (control bit 1 = 0) with counting enabled (control bit 0 = 1), the count goes up by one for each rising input transition when control bit 2 is 0, or for each falling transition when it is 1. The new count is readable within 4 clock cycles of the pin change.
- R3: In gated mode (control bit 1 = 1) with counting enabled, the count goes up by one on each cycle where `tick_in` is 1 and the synchronized input is at its active level. The active level is high when control bit 2 is 0 and low when it is 1.
- R4: While control bit 0 is 0, the count does not change and neither flag sets, whatever happens on the input and on `tick_in`.
- R5: The overflow flag (flag bit 1) sets when an increment takes the count from 0xFFFF to 0x0000.
- R6: The input flag (flag bit 0) sets on each counted transition in event mode. In gated mode it sets when the input leaves its active level (the gate's trailing edge).
- R7: A write to address 1 clears flag bit 1 when data bit 1 is 1, and clears flag bit 0 when data bit 0 is 1. Writing 0 to a flag bit leaves it unchanged. Flag byte bits 7 to 2 read as 0.
- R8: With control bit 3 set, any read or write at address 2 or 3 clears both flags.
- R9: If a flag is set by hardware in the same cycle that software clears it, the flag ends up set.
- R10: A write to the count takes effect in place of any increment that falls in the same cycle.
- R11: A word access (`bus_word` = 1) at address 2 reads or writes all 16 count bits in one cycle. A byte access at address 2 reaches bits 15:8 and one at address 3 reaches bits 7:0, and a byte read returns the byte in data bits 7:0 with zeros above.
- R12: `irq` is 1 exactly when flag bit 1 is set with control bit 4 set, or when flag bit 0 is set with control bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| tick_in | input | 1 | Prescaled-clock strobe for gated mode, one cycle per tick |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 16-bit count access |
| bus_addr | input | 2 | Register address: 0 control, 1 flags, 2 count high, 3 count low |
| bus_wdata | input | 16 | Write data (bytes use bits 7:0) |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the input pin holds each level for at least two clock cycles, and that the edge polarity changes only while counting is disabled. A polarity flip while counting would look like an input transition. The stimulus changes polarity only with the enable bit clear, waits for the synchronizer to settle before enabling, and holds each random pin level for two to five cycles. In the gated runs, ticks are issued only after the new gate level has passed through the synchronizer, so the expected count is the number of ticks seen at the active level.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CHI  = 2'd2;
  localparam logic [1:0] ADDR_CLO  = 2'd3;

  // control byte, bit 0 at the bottom
  typedef struct packed {
    logic ie_edge;   // bit 5
    logic ie_ovf;    // bit 4
    logic fast_clr;  // bit 3
    logic pol;       // bit 2
    logic gated;     // bit 1
    logic en;        // bit 0
  } pa_ctrl_t;

  localparam int CTRL_W = $bits(pa_ctrl_t);
  localparam int FLAG_OVF  = 1;
  localparam int FLAG_EDGE = 0;
endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic level_act,
  output logic lead,
  output logic trail
);
  logic [STAGES:0] chain;
  logic cur_act, old_act;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign cur_act   = chain[STAGES-1] ^ pol;
  assign old_act   = chain[STAGES] ^ pol;
  assign level_act = cur_act;
  assign lead      = cur_act & ~old_act;
  assign trail     = ~cur_act & old_act;

  // R2: a detected edge lasts a single cycle
  p_lead_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead);
  p_trail_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !trail);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld_hi,
  input  logic         ld_lo,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam int HALF = W / 2;

  logic any_ld;
  assign any_ld = ld_hi | ld_lo;
  assign wrap   = inc & (&cnt) & ~any_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (any_ld) begin
      cnt[W-1:HALF] <= ld_hi ? ld_data[W-1:HALF] : cnt[W-1:HALF];
      cnt[HALF-1:0] <= ld_lo ? ld_data[HALF-1:0] : cnt[HALF-1:0];
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && ld_lo) |=> cnt == $past(ld_data));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !any_ld) |=> $stable(cnt));
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
endmodule

// File: rtl/pa_flags.sv
module pa_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_ovf,
  input  logic       set_edge,
  input  logic [1:0] clr_mask,
  input  logic       clr_all,
  output logic [1:0] flags
);
  logic [1:0] setv, clrv;
  assign setv = {set_ovf, set_edge};
  assign clrv = clr_mask | {2{clr_all}};

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clrv) | setv;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> flags[1]);
  p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_edge |=> flags[0]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[1] && !set_ovf) |=> !flags[1]);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(set_ovf));
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             tick_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_word,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  import pa_pkg::*;
  localparam int HALF = CNT_W / 2;

  pa_ctrl_t          ctrl;
  logic [1:0]        flags;
  logic [CNT_W-1:0]  cnt, ld_data;
  logic              level_act, lead, trail, wrap;
  logic              inc, set_edge, wr_cnt, cnt_acc, ld_hi, ld_lo, clr_all;
  logic [1:0]        w1c;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (bus_sel && bus_wr && bus_addr == ADDR_CTRL) ctrl <= pa_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .pol(ctrl.pol),
    .level_act(level_act), .lead(lead), .trail(trail));

  assign inc      = ctrl.en & (ctrl.gated ? (level_act & tick_in) : lead);
  assign set_edge = ctrl.en & (ctrl.gated ? trail : lead);

  assign cnt_acc = bus_sel & bus_addr[1];
  assign wr_cnt  = cnt_acc & bus_wr;
  assign ld_hi   = wr_cnt & (bus_word | bus_addr == ADDR_CHI);
  assign ld_lo   = wr_cnt & (bus_word | bus_addr == ADDR_CLO);
  assign ld_data = bus_word ? bus_wdata : {2{bus_wdata[HALF-1:0]}};

  pa_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_data(ld_data), .cnt(cnt), .wrap(wrap));

  assign w1c     = (bus_sel && bus_wr && bus_addr == ADDR_FLAG) ? bus_wdata[1:0] : 2'b00;
  assign clr_all = ctrl.fast_clr & cnt_acc;

  pa_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ovf(wrap), .set_edge(set_edge),
    .clr_mask(w1c), .clr_all(clr_all), .flags(flags));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
      ADDR_FLAG: bus_rdata[1:0] = flags;
      ADDR_CHI:  bus_rdata = bus_word ? cnt : {{HALF{1'b0}}, cnt[CNT_W-1:HALF]};
      default:   bus_rdata = bus_word ? cnt : {{HALF{1'b0}}, cnt[HALF-1:0]};
    endcase
  end

  assign irq = (flags[FLAG_OVF] & ctrl.ie_ovf) | (flags[FLAG_EDGE] & ctrl.ie_edge);

  p_fast_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wrap && !set_edge) |=> flags == 2'b00);
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !wr_cnt) |=> $stable(cnt));
  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != 2'b00);
endmodule

// File: tb/test_pulse_acc.sv
module test_pulse_acc;
  logic clk = 1'b0, rst_n = 1'b0, pin_in = 1'b0, tick_in = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pulse_acc i_pulse_acc (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick_in(tick_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic w);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_word = w;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_word = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic w, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; bus_word = w;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_word = 0;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  function automatic logic [15:0] exp_sum(input logic [15:0] s, input int n);
    return 16'(s + n);
  endfunction
  function automatic logic exp_wrap(input logic [15:0] s, input int n);
    return (32'(s) + n) > 32'hFFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 0, d); chk("R1 ctrl", d, 0);
    rd(1, 0, d); chk("R1 flags", d, 0);
    rd(2, 1, d); chk("R1 count", d, 0);
    chk("R1 irq", {15'b0, irq}, 0);

    // R11 byte and word access
    wr(2, 16'h00AB, 0); wr(3, 16'h00CD, 0);
    rd(2, 1, d); chk("R11 word read", d, 16'hABCD);
    rd(2, 0, d); chk("R11 high byte", d, 16'h00AB);
    rd(3, 0, d); chk("R11 low byte", d, 16'h00CD);
    wr(2, 16'h5A3C, 1);
    rd(2, 1, d); chk("R11 word write", d, 16'h5A3C);

    // R4 disabled: pin toggles ignored
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; repeat (3) @(negedge clk); end
    settle();
    rd(2, 1, d); chk("R4 count held", d, 16'h5A3C);
    rd(1, 0, d); chk("R4 no flags", d, 0);

    // R5 R6 R7 overflow and edge flag, write-one-to-clear
    pin_in = 0; settle();
    wr(2, 16'hFFFF, 1);
    wr(0, 16'h0001, 0);
    pin_in = 1; settle();
    rd(2, 1, d); chk("R5 wrapped count", d, 0);
    rd(1, 0, d); chk("R5 R6 flags set", d, 16'h0003);
    wr(1, 16'h00FC, 0);
    rd(1, 0, d); chk("R7 zeros no effect", d, 16'h0003);
    wr(1, 16'h0002, 0);
    rd(1, 0, d); chk("R7 clear ovf", d, 16'h0001);
    wr(1, 16'h0001, 0);
    rd(1, 0, d); chk("R7 clear edge", d, 0);

    // R12 interrupt
    wr(0, 16'h0021, 0);
    pin_in = 0; settle(); pin_in = 1; settle();
    chk("R12 irq edge", {15'b0, irq}, 1);
    wr(0, 16'h0011, 0);
    chk("R12 irq masked", {15'b0, irq}, 0);
    wr(1, 16'h0003, 0);

    // R8 fast clear on count read
    wr(0, 16'h0009, 0);
    pin_in = 0; settle(); pin_in = 1; settle();
    rd(1, 0, d); chk("R8 flag before", d, 16'h0001);
    rd(3, 0, d);
    rd(1, 0, d); chk("R8 fast clear", d, 0);

    // R3 R6 gated mode, trailing edge
    wr(0, 16'h0000, 0); pin_in = 0; settle();
    wr(2, 16'h0000, 1);
    wr(0, 16'h0003, 0);
    pin_in = 1; settle();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); tick_in = (i % 2 == 0);
    end
    @(negedge clk); tick_in = 0;
    rd(1, 0, d); chk("R6 no trail yet", d, 0);
    pin_in = 0; settle();
    rd(2, 1, d); chk("R3 gated count", d, 16'd4);
    rd(1, 0, d); chk("R6 trailing edge", d, 16'h0001);
    wr(1, 16'h0003, 0);

    // R10 load beats increment
    pin_in = 1; settle();
    @(negedge clk); tick_in = 1; bus_sel = 1; bus_wr = 1; bus_word = 1; bus_addr = 2; bus_wdata = 16'h1234;
    @(negedge clk); tick_in = 0; bus_sel = 0; bus_wr = 0; bus_word = 0;
    rd(2, 1, d); chk("R10 load wins", d, 16'h1234);

    // R9 set wins over clear
    wr(2, 16'hFFFF, 1);
    @(negedge clk); tick_in = 1; bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 16'h0002;
    @(negedge clk); tick_in = 0; bus_sel = 0; bus_wr = 0;
    rd(1, 0, d); chk("R9 set wins", d, 16'h0002);
    rd(2, 1, d); chk("R9 count wrapped", d, 0);
    wr(1, 16'h0003, 0);

    // random event mode runs (R2, R5, R6)
    for (int r = 0; r < 12; r++) begin
      logic pol; logic [15:0] start; int n;
      pol = 1'($urandom % 2);
      start = ($urandom % 2) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom);
      n = 0;
      wr(0, {13'b0, pol, 2'b00}, 0); settle();
      wr(1, 16'h0003, 0);
      wr(2, start, 1);
      wr(0, {13'b0, pol, 2'b01}, 0);
      for (int k = 0; k < 2 + int'($urandom % 20); k++) begin
        pin_in = ~pin_in;
        if ((pin_in ^ pol) == 1'b1) n++;
        repeat (2 + $urandom % 4) @(negedge clk);
      end
      settle();
      rd(2, 1, d); chk("R2 random event count", d, exp_sum(start, n));
      rd(1, 0, d); chk("R2 R5 random flags", d,
        {14'b0, exp_wrap(start, n), 1'(n > 0)});
    end

    // random gated runs (R3)
    for (int r = 0; r < 8; r++) begin
      logic pol; int n; logic trailed;
      pol = 1'($urandom % 2);
      n = 0; trailed = 0;
      wr(0, {13'b0, pol, 2'b10}, 0); settle();
      wr(1, 16'h0003, 0);
      wr(2, 16'h0100, 1);
      wr(0, {13'b0, pol, 2'b11}, 0);
      for (int s = 0; s < 6; s++) begin
        logic nv;
        nv = 1'($urandom % 2);
        if (((pin_in ^ pol) == 1'b1) && ((nv ^ pol) == 1'b0)) trailed = 1;
        pin_in = nv; settle();
        for (int t = 0; t < 1 + int'($urandom % 8); t++) begin
          @(negedge clk); tick_in = 1'($urandom % 2);
          if (tick_in && ((pin_in ^ pol) == 1'b1)) n++;
        end
        @(negedge clk); tick_in = 0;
      end
      rd(2, 1, d); chk("R3 random gated count", d, exp_sum(16'h0100, n));
      rd(1, 0, d); chk("R6 random gated flag", d, {15'b0, trailed});
    end
    summary();
  end
endmodule